// File: doc/BRIEF.md
# Memory Low-Power Mode Sequencer

This block sits on the controller side of a mobile double-data-rate memory interface and owns the clock-enable pin. It takes requests to enter and leave three low-power states: power-down, self refresh and deep power-down. It checks whether each entry is allowed, drives the one-cycle entry command with clock-enable low, and holds the command bus at NOP while an exit recovery time runs. Each mode has its own exit rule. Leaving power-down waits a programmable number of cycles. Leaving self refresh waits the self-refresh exit delay, and only NOPs are driven during that wait. Leaving deep power-down needs a stable clock and then raises a sticky flag saying that the memory must be initialized again.

The rest of the controller reads `busy` to know when it may issue normal commands. It watches `req_err` to learn that an entry request was refused. It asks for permission to gate the memory clock through `clk_stop_req`/`clk_stop_ok`. The initialization sequence and the refresh interval timers are outside this block. Self refresh is meant for retention while the controller is parked and does not replace periodic auto refresh; the block leaves that scheduling to its neighbours.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset `cke`=1, `cmd`=NOP (0), `busy`=0, `reinit_req`=0, `req_err`=0 and `lp_mode`=ACTIVE (0).
- R2: A power-down request taken in ACTIVE drives `cke` low with `cmd`=NOP from the next cycle, whether `banks_idle` is high or low. `lp_mode` reads 1 and `busy` stays high for the whole time `cke` is low.
- R3: A self-refresh request is taken only when `banks_idle`=1. On the next cycle `cke` goes low and `cmd`=SREF (1) for exactly one cycle, then NOP, and `lp_mode`=2.
- R4: A deep power-down request is taken only when `banks_idle`=1 and `bus_quiet`=1. On the next cycle `cmd`=DPD (2) for exactly one cycle, and `cke` stays low for as long as `lp_mode`=3.
- R5: An entry request made in ACTIVE is refused when its precondition fails or while `reinit_req`=1. A refused request gives a one-cycle `req_err` pulse on the next cycle and leaves `cke` high and `lp_mode` at 0.
- R6: When several entry requests arrive together, only the highest one counts, in the order deep power-down, then self refresh, then power-down. A refused higher request does not fall back to a lower one.
- R7: A power-down exit request raises `cke` on the next cycle. `cmd` stays NOP and `busy` stays high for max(`t_xp`,1) cycles before ACTIVE.
- R8: A self-refresh exit request raises `cke` on the next cycle. `cmd` stays NOP and `busy` stays high for max(`t_xsr`,1) cycles. `lp_mode` reads 0 whenever `cke` is high.
- R9: A deep power-down exit request is ignored while `clk_stable`=0, and `cke` stays low. With `clk_stable`=1, `cke` rises on the next cycle and the block returns to ACTIVE.
- R10: Leaving deep power-down sets `reinit_req`. It stays set until `init_done` is sampled high.
- R11: `clk_stop_ok` is high only when `clk_stop_req`=1, the block is in ACTIVE and not busy, `ops_inflight`=0, and no entry request is present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_enter_req | input | 1 | Request power-down entry |
| pd_exit_req | input | 1 | Request power-down exit |
| sr_enter_req | input | 1 | Request self-refresh entry |
| sr_exit_req | input | 1 | Request self-refresh exit |
| dpd_enter_req | input | 1 | Request deep power-down entry |
| dpd_exit_req | input | 1 | Request deep power-down exit |
| banks_idle | input | 1 | All banks precharged |
| bus_quiet | input | 1 | No data burst on the data bus |
| ops_inflight | input | 1 | A memory operation is still in progress |
| clk_stable | input | 1 | Memory clock is running and stable |
| clk_stop_req | input | 1 | Controller wants to stop the memory clock |
| init_done | input | 1 | External initialization sequence has finished |
| t_xp | input | TW | Power-down exit delay in cycles |
| t_xsr | input | TW | Self-refresh exit delay in cycles |
| cke | output | 1 | Clock-enable level to the memory |
| cmd | output | 2 | Command to drive: 0 NOP, 1 SREF, 2 DPD |
| busy | output | 1 | Normal commands are not allowed |
| req_err | output | 1 | One-cycle pulse when an entry request is refused |
| reinit_req | output | 1 | Memory needs full initialization |
| lp_mode | output | 2 | 0 active, 1 power-down, 2 self refresh, 3 deep power-down |
| clk_stop_ok | output | 1 | Memory clock may be stopped this cycle |

## Verification
The bound checker watches several rules on every cycle. An entry command lasts one cycle and only with `cke` low. SREF and DPD appear only after their idle conditions held. `busy` covers every cycle with `cke` low. A refusal never changes the pin state. `cke` can rise out of deep power-down only with a stable clock, and doing so raises the sticky re-initialization flag. `clk_stop_ok` never coincides with work in flight. Some behaviour can only be shown by the bench's scenarios: the exact length of each exit wait against its programmed delay, the request priority and the fact that a refused request does not fall back, and the fact that a deep power-down exit request is ignored while the clock is unstable.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power mode sequencer.
// Assumes: the command code is decoded by the command-bus driver next door.
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_ACT      = 3'd0,
        ST_PD       = 3'd1,
        ST_SR_ENT   = 3'd2,
        ST_SR       = 3'd3,
        ST_DPD_ENT  = 3'd4,
        ST_DPD      = 3'd5,
        ST_XP_WAIT  = 3'd6,
        ST_XSR_WAIT = 3'd7
    } lpm_state_e;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_SREF = 2'd1,
        CMD_DPD  = 2'd2
    } lpm_cmd_e;

    localparam logic [1:0] MODE_ACT = 2'd0;
    localparam logic [1:0] MODE_PD  = 2'd1;
    localparam logic [1:0] MODE_SR  = 2'd2;
    localparam logic [1:0] MODE_DPD = 2'd3;

endpackage

// File: rtl/lpm_exit_timer.sv
// Exit recovery down-counter.
// Loads a delay and reports done once the wait has lasted max(delay,1) cycles.
// Assumes: load is pulsed on the edge where the wait state is entered.
module lpm_exit_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] cnt_q;

    // Count down towards one; loading takes priority over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q > ONE)
            cnt_q <= cnt_q - ONE;
    end

    assign done = (cnt_q <= ONE);

endmodule

// File: rtl/lpm_req_gate.sv
// Entry-request arbiter and precondition check.
// Picks the highest pending entry request (deep power-down, self refresh,
// power-down) and accepts it only if its idle precondition holds. It also
// decides whether the memory clock may be stopped.
// Assumes: in_active is high only when the sequencer is in ACTIVE and idle.
module lpm_req_gate (
    input  logic in_active,
    input  logic reinit,
    input  logic pd_req,
    input  logic sr_req,
    input  logic dpd_req,
    input  logic banks_idle,
    input  logic bus_quiet,
    input  logic ops_inflight,
    input  logic clk_stop_req,
    output logic go_pd,
    output logic go_sr,
    output logic go_dpd,
    output logic refuse,
    output logic stop_ok
);
    logic any_req;
    logic pre_ok;

    // Priority select of the single request that counts, and its precondition.
    always_comb begin
        any_req = pd_req | sr_req | dpd_req;
        if (dpd_req)
            pre_ok = banks_idle & bus_quiet;
        else if (sr_req)
            pre_ok = banks_idle;
        else
            pre_ok = 1'b1;
        pre_ok = pre_ok & ~reinit;
    end

    // Accept or refuse; nothing outside ACTIVE counts as an entry request.
    always_comb begin
        go_dpd = in_active & dpd_req & pre_ok;
        go_sr  = in_active & ~dpd_req & sr_req & pre_ok;
        go_pd  = in_active & ~dpd_req & ~sr_req & pd_req & pre_ok;
        refuse = in_active & any_req & ~pre_ok;
    end

    // The clock may stop only with nothing in flight and nothing about to start.
    assign stop_ok = in_active & clk_stop_req & ~ops_inflight & ~any_req;

endmodule

// File: rtl/lpm_fsm.sv
// Mode state machine: owns the state register, the refusal pulse, the
// re-initialization flag and the decode of clock-enable, command and mode.
// Assumes: go_* and refuse come from lpm_req_gate and are one-hot or zero.
module lpm_fsm
    import lpm_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_pd,
    input  logic          go_sr,
    input  logic          go_dpd,
    input  logic          refuse,
    input  logic          pd_exit_req,
    input  logic          sr_exit_req,
    input  logic          dpd_exit_req,
    input  logic          clk_stable,
    input  logic          init_done,
    input  logic [TW-1:0] t_xp,
    input  logic [TW-1:0] t_xsr,
    input  logic          tmr_done,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          in_active,
    output logic          cke,
    output logic [1:0]    cmd,
    output logic          busy,
    output logic [1:0]    lp_mode,
    output logic          req_err,
    output logic          reinit_req
);
    lpm_state_e st_q, st_d;
    logic       dpd_leave;

    // Next-state logic with the per-mode exit rules.
    always_comb begin
        st_d      = st_q;
        tmr_load  = 1'b0;
        tmr_val   = t_xp;
        dpd_leave = 1'b0;
        unique case (st_q)
            ST_ACT: begin
                if (go_dpd)     st_d = ST_DPD_ENT;
                else if (go_sr) st_d = ST_SR_ENT;
                else if (go_pd) st_d = ST_PD;
            end
            ST_PD: begin
                if (pd_exit_req) begin
                    st_d     = ST_XP_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = t_xp;
                end
            end
            ST_SR_ENT: st_d = ST_SR;
            ST_SR: begin
                if (sr_exit_req) begin
                    st_d     = ST_XSR_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = t_xsr;
                end
            end
            ST_DPD_ENT: st_d = ST_DPD;
            ST_DPD: begin
                if (dpd_exit_req && clk_stable) begin
                    st_d      = ST_ACT;
                    dpd_leave = 1'b1;
                end
            end
            ST_XP_WAIT, ST_XSR_WAIT: begin
                if (tmr_done) st_d = ST_ACT;
            end
            default: st_d = ST_ACT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_ACT;
        else        st_q <= st_d;
    end

    // One-cycle refusal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) req_err <= 1'b0;
        else        req_err <= refuse;
    end

    // Sticky re-initialization flag: set on deep power-down exit, cleared by init_done.
    always_ff @(posedge clk) begin
        if (!rst_n)         reinit_req <= 1'b0;
        else if (dpd_leave) reinit_req <= 1'b1;
        else if (init_done) reinit_req <= 1'b0;
    end

    // Pin and status decode from the registered state.
    always_comb begin
        in_active = (st_q == ST_ACT);
        busy      = ~in_active;
        cke       = 1'b1;
        cmd       = CMD_NOP;
        lp_mode   = MODE_ACT;
        unique case (st_q)
            ST_PD:      begin cke = 1'b0; lp_mode = MODE_PD; end
            ST_SR_ENT:  begin cke = 1'b0; lp_mode = MODE_SR; cmd = CMD_SREF; end
            ST_SR:      begin cke = 1'b0; lp_mode = MODE_SR; end
            ST_DPD_ENT: begin cke = 1'b0; lp_mode = MODE_DPD; cmd = CMD_DPD; end
            ST_DPD:     begin cke = 1'b0; lp_mode = MODE_DPD; end
            default:    ;
        endcase
    end

endmodule

// File: rtl/lpm_sequencer.sv
// Top of the low-power mode sequencer: request gate, mode state machine and
// exit timer. Drives clock-enable and the low-power entry commands.
// Assumes: the command-bus driver issues this block's cmd whenever busy is high.
module lpm_sequencer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pd_enter_req,
    input  logic          pd_exit_req,
    input  logic          sr_enter_req,
    input  logic          sr_exit_req,
    input  logic          dpd_enter_req,
    input  logic          dpd_exit_req,
    input  logic          banks_idle,
    input  logic          bus_quiet,
    input  logic          ops_inflight,
    input  logic          clk_stable,
    input  logic          clk_stop_req,
    input  logic          init_done,
    input  logic [TW-1:0] t_xp,
    input  logic [TW-1:0] t_xsr,
    output logic          cke,
    output logic [1:0]    cmd,
    output logic          busy,
    output logic          req_err,
    output logic          reinit_req,
    output logic [1:0]    lp_mode,
    output logic          clk_stop_ok
);
    logic go_pd, go_sr, go_dpd, refuse, in_active;
    logic tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;

    lpm_req_gate u_gate (
        .in_active    (in_active),
        .reinit       (reinit_req),
        .pd_req       (pd_enter_req),
        .sr_req       (sr_enter_req),
        .dpd_req      (dpd_enter_req),
        .banks_idle   (banks_idle),
        .bus_quiet    (bus_quiet),
        .ops_inflight (ops_inflight),
        .clk_stop_req (clk_stop_req),
        .go_pd        (go_pd),
        .go_sr        (go_sr),
        .go_dpd       (go_dpd),
        .refuse       (refuse),
        .stop_ok      (clk_stop_ok)
    );

    lpm_fsm #(.TW(TW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_pd        (go_pd),
        .go_sr        (go_sr),
        .go_dpd       (go_dpd),
        .refuse       (refuse),
        .pd_exit_req  (pd_exit_req),
        .sr_exit_req  (sr_exit_req),
        .dpd_exit_req (dpd_exit_req),
        .clk_stable   (clk_stable),
        .init_done    (init_done),
        .t_xp         (t_xp),
        .t_xsr        (t_xsr),
        .tmr_done     (tmr_done),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .in_active    (in_active),
        .cke          (cke),
        .cmd          (cmd),
        .busy         (busy),
        .lp_mode      (lp_mode),
        .req_err      (req_err),
        .reinit_req   (reinit_req)
    );

    lpm_exit_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

endmodule

// File: rtl/lpm_sequencer_chk.sv
// Property checker for lpm_sequencer, attached by bind. Watches only ports.
module lpm_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic [1:0] cmd,
    input logic       busy,
    input logic       req_err,
    input logic       reinit_req,
    input logic       init_done,
    input logic [1:0] lp_mode,
    input logic       banks_idle,
    input logic       bus_quiet,
    input logic       clk_stable,
    input logic       ops_inflight,
    input logic       clk_stop_ok
);
    assert_lowpower_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> busy);

    assert_entry_cmd_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 2'd0 |=> cmd == 2'd0);

    assert_sref_needs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'd1 |-> $past(banks_idle));

    assert_entry_cmd_cke_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 2'd0 |-> !cke);

    assert_dpd_needs_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'd2 |-> $past(banks_idle && bus_quiet));

    assert_refusal_keeps_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> cke && lp_mode == 2'd0 && $past(!busy));

    assert_dpd_exit_stable_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lp_mode) == 2'd3 && cke) |-> $past(clk_stable));

    assert_dpd_exit_sets_reinit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lp_mode) == 2'd3 && cke) |-> reinit_req);

    assert_reinit_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reinit_req && !init_done) |=> reinit_req);

    assert_clk_stop_safe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_ok |-> !ops_inflight && !busy && cke);

endmodule

bind lpm_sequencer lpm_sequencer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke          (cke),
    .cmd          (cmd),
    .busy         (busy),
    .req_err      (req_err),
    .reinit_req   (reinit_req),
    .init_done    (init_done),
    .lp_mode      (lp_mode),
    .banks_idle   (banks_idle),
    .bus_quiet    (bus_quiet),
    .clk_stable   (clk_stable),
    .ops_inflight (ops_inflight),
    .clk_stop_ok  (clk_stop_ok)
);

// File: tb/lpm_sequencer_tb.sv
// Directed bench for lpm_sequencer: one task per scenario.
module lpm_sequencer_tb;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    // rq bits: 0 pd_enter 1 pd_exit 2 sr_enter 3 sr_exit 4 dpd_enter 5 dpd_exit 6 init_done
    logic [6:0] rq = '0;
    logic banks_idle = 1'b1, bus_quiet = 1'b1, ops_inflight = 1'b0;
    logic clk_stable = 1'b1, clk_stop_req = 1'b0;
    logic [TW-1:0] t_xp = 8'd3, t_xsr = 8'd5;
    logic cke, busy, req_err, reinit_req, clk_stop_ok;
    logic [1:0] cmd, lp_mode;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    lpm_sequencer #(.TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .pd_enter_req(rq[0]), .pd_exit_req(rq[1]),
        .sr_enter_req(rq[2]), .sr_exit_req(rq[3]),
        .dpd_enter_req(rq[4]), .dpd_exit_req(rq[5]),
        .banks_idle(banks_idle), .bus_quiet(bus_quiet),
        .ops_inflight(ops_inflight), .clk_stable(clk_stable),
        .clk_stop_req(clk_stop_req), .init_done(rq[6]),
        .t_xp(t_xp), .t_xsr(t_xsr),
        .cke(cke), .cmd(cmd), .busy(busy), .req_err(req_err),
        .reinit_req(reinit_req), .lp_mode(lp_mode), .clk_stop_ok(clk_stop_ok)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Hold a request pattern for one capturing edge; returns at the next negedge.
    task automatic pulse(input logic [6:0] m);
        @(negedge clk) rq = m;
        @(negedge clk) rq = '0;
    endtask

    task automatic t_reset();
        chk("R1 cke", cke, 1);
        chk("R1 cmd", cmd, 0);
        chk("R1 busy", busy, 0);
        chk("R1 reinit", reinit_req, 0);
        chk("R1 err", req_err, 0);
        chk("R1 mode", lp_mode, 0);
    endtask

    task automatic t_pd();
        banks_idle = 1'b0;
        pulse(7'b0000001);
        chk("R2 cke low", cke, 0);
        chk("R2 cmd nop", cmd, 0);
        chk("R2 mode", lp_mode, 1);
        chk("R2 busy", busy, 1);
        repeat (3) @(negedge clk);
        chk("R2 cke held", cke, 0);
        pulse(7'b0000010);
        chk("R7 cke up", cke, 1);
        chk("R7 mode", lp_mode, 0);
        for (int i = 1; i < 3; i++) begin
            @(negedge clk);
            chk("R7 busy in wait", busy, 1);
        end
        @(negedge clk);
        chk("R7 busy cleared", busy, 0);
        banks_idle = 1'b1;
    endtask

    task automatic t_sr();
        pulse(7'b0000100);
        chk("R3 cmd sref", cmd, 1);
        chk("R3 cke low", cke, 0);
        chk("R3 mode", lp_mode, 2);
        @(negedge clk);
        chk("R3 cmd back to nop", cmd, 0);
        chk("R3 cke stays low", cke, 0);
        pulse(7'b0001000);
        chk("R8 cke up", cke, 1);
        chk("R8 mode", lp_mode, 0);
        for (int i = 1; i < 5; i++) begin
            @(negedge clk);
            chk("R8 busy in wait", busy, 1);
            chk("R8 nop in wait", cmd, 0);
        end
        @(negedge clk);
        chk("R8 busy cleared", busy, 0);
    endtask

    task automatic t_dpd();
        pulse(7'b0010000);
        chk("R4 cmd dpd", cmd, 2);
        chk("R4 cke low", cke, 0);
        chk("R4 mode", lp_mode, 3);
        @(negedge clk);
        chk("R4 cmd nop", cmd, 0);
        clk_stable = 1'b0;
        pulse(7'b0100000);
        chk("R9 unstable exit ignored cke", cke, 0);
        chk("R9 unstable exit ignored mode", lp_mode, 3);
        clk_stable = 1'b1;
        pulse(7'b0100000);
        chk("R9 cke up", cke, 1);
        chk("R9 mode active", lp_mode, 0);
        chk("R10 reinit set", reinit_req, 1);
        repeat (3) @(negedge clk);
        chk("R10 reinit sticky", reinit_req, 1);
        pulse(7'b0000001);
        chk("R5 err while reinit", req_err, 1);
        chk("R5 cke kept", cke, 1);
        @(negedge clk);
        chk("R5 err is a pulse", req_err, 0);
        pulse(7'b1000000);
        chk("R10 reinit cleared", reinit_req, 0);
    endtask

    task automatic t_refuse();
        banks_idle = 1'b0;
        pulse(7'b0000100);
        chk("R5 sr refused err", req_err, 1);
        chk("R5 sr refused cke", cke, 1);
        chk("R5 sr refused mode", lp_mode, 0);
        banks_idle = 1'b1;
        bus_quiet  = 1'b0;
        pulse(7'b0010000);
        chk("R5 dpd refused err", req_err, 1);
        chk("R5 dpd refused mode", lp_mode, 0);
        bus_quiet = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_priority();
        pulse(7'b0010101);
        chk("R6 dpd wins", cmd, 2);
        pulse(7'b0100000);
        pulse(7'b1000000);
        banks_idle = 1'b0;
        pulse(7'b0000101);
        chk("R6 no fallback err", req_err, 1);
        chk("R6 no fallback cke", cke, 1);
        banks_idle = 1'b1;
        pulse(7'b0000101);
        chk("R6 sr over pd", cmd, 1);
        pulse(7'b0001000);
        repeat (6) @(negedge clk);
        chk("R6 back active", busy, 0);
    endtask

    task automatic t_clkstop();
        @(negedge clk);
        clk_stop_req = 1'b1;
        ops_inflight = 1'b1;
        #1 chk("R11 inflight blocks", clk_stop_ok, 0);
        ops_inflight = 1'b0;
        #1 chk("R11 granted", clk_stop_ok, 1);
        rq = 7'b0000001;
        #1 chk("R11 entry request blocks", clk_stop_ok, 0);
        @(negedge clk) rq = '0;
        #1 chk("R11 power-down blocks", clk_stop_ok, 0);
        clk_stop_req = 1'b0;
        pulse(7'b0000010);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pd();
        t_sr();
        t_dpd();
        t_refuse();
        t_priority();
        t_clkstop();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule